// File: doc/BRIEF.md
# Run-Time Programmable Sum-of-Products Array

This block is a two-level logic array whose contents are loaded while the chip runs. It has N_IN inputs, N_TERM product terms and N_OUT outputs. A product-term plane says, for each term and each input, whether the input enters the term true, enters it inverted, stays out of it, or forces the term low. A sum plane says which terms are ORed into which outputs. Once loaded, the outputs follow the inputs combinationally through the two planes, with no clock in the path.

A build parameter picks between two sum-plane topologies. In the shared mode any term may drive any number of outputs, so a common term is computed once and reused. In the grouped mode output k can only reach its own fixed slice of PAL_GRP terms, starting at term k*PAL_GRP. Sum-plane bits that point outside that slice are stored but have no effect.

Rows are written through a registered port, one term row per write. A small controller with three states, ST_BLANK, ST_LOAD and ST_ARMED, tracks the load. Reset enters ST_BLANK. Any write moves the controller to ST_LOAD, from any state. A commit pulse without a write moves it to ST_ARMED. A commit and a write in the same cycle: the write wins. `load_done` is high only in ST_ARMED. While it is low, every output is held at 0.

Top module: `sop_array`

## Requirements
- R1: After reset, `load_done` is 0, every output is 0, and every stored cell and connection is 0.
- R2: A product-term cell uses a 2-bit code: 2'b10 takes the input true, 2'b01 takes it complemented, 2'b11 leaves it out of the term, and 2'b00 forces the whole term to 0. In a term row, the cell for input i sits at data bits [2i+1:2i].
- R3: A term whose cells are all 2'b11 evaluates to 1 for every input value.
- R4: Each output is the OR of the terms connected to it, and an output with no connected term is 0. In a sum row, bit k connects that term to output k.
- R5: In shared mode (MODE = ARR_PLA), one term may drive several outputs at once, and any term may reach any output.
- R6: In grouped mode (MODE = ARR_PAL), output k uses only terms k*PAL_GRP to k*PAL_GRP+PAL_GRP-1. A connection bit set for any other term has no effect on output k.
- R7: A write with `wr_en` high stores `wr_data` into row `wr_row` of the plane chosen by `wr_plane` (0 = product plane, 1 = sum plane). The new row acts on the outputs from the next clock edge onward.
- R8: `load_done` goes high on the edge after a commit taken without a write. It goes low on the edge after any write. It holds its value otherwise, and while it is low all outputs are 0.
- R9: In shared mode with A, B and C on inputs 0, 1 and 2, the five terms A·B, B'·C, A·C', B'·C' and A together give F0 = A + B'C', F1 = AC' + AB, F2 = B'C' + AB and F3 = B'C + A for all eight input combinations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Row write strobe |
| wr_plane | input | 1 | Plane select: 0 product plane, 1 sum plane |
| wr_row | input | ROW_W | Term row index |
| wr_data | input | DW | Row contents (2 bits per input, or 1 bit per output) |
| commit | input | 1 | Marks the load complete |
| x_in | input | N_IN | Array inputs |
| f_out | output | N_OUT | Array outputs |
| load_done | output | 1 | Array is loaded and outputs are live |

## Verification
The bench drives one stimulus stream into a shared-mode instance and a grouped-mode instance. Both are compared every cycle against a behavioural model, and each check is labelled with the requirement it covers.

The directed cases target these errors:
- A swapped true/complement encoding would give the wrong truth table for the five-term example.
- A forced-zero code treated as "leave out" would keep a term alive.
- A missing default of 1 for an all-excluded term would leave a constant output at 0.
- A grouped array that honoured out-of-group connection bits would drive outputs the shared-only setup drives.
- An output left high while a load is pending would show through `load_done` low.

A random phase mixes writes, commits and input changes back to back. It exposes off-by-one-cycle write timing and any mistake in write-over-commit priority.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef enum logic [1:0] {
        ST_BLANK = 2'd0,
        ST_LOAD  = 2'd1,
        ST_ARMED = 2'd2
    } cfg_state_e;

    typedef enum logic {
        ARR_PLA = 1'b0,
        ARR_PAL = 1'b1
    } arr_mode_e;

    localparam logic [1:0] CELL_ZERO = 2'b00;
    localparam logic [1:0] CELL_NEG  = 2'b01;
    localparam logic [1:0] CELL_POS  = 2'b10;
    localparam logic [1:0] CELL_FREE = 2'b11;

    localparam logic PLANE_PROD = 1'b0;
    localparam logic PLANE_SUM  = 1'b1;

endpackage

// File: rtl/sop_cfg_ctrl.sv
module sop_cfg_ctrl
    import sop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic commit,
    output logic load_done
);

    cfg_state_e state_q;
    cfg_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK: begin
                if (wr_en)       state_d = ST_LOAD;
                else if (commit) state_d = ST_ARMED;
            end
            ST_LOAD: begin
                if (wr_en)       state_d = ST_LOAD;
                else if (commit) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (wr_en)       state_d = ST_LOAD;
            end
            default: state_d = ST_BLANK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BLANK;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_ARMED: load_done = 1'b1;
            default:  load_done = 1'b0;
        endcase
    end

endmodule

// File: rtl/sop_prod_plane.sv
module sop_prod_plane
    import sop_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_TERM = 16,
    parameter int ROW_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [2*N_IN-1:0] data,
    input  logic [N_IN-1:0]   x,
    output logic [N_TERM-1:0] term_hit
);

    logic [2*N_IN-1:0] cells_q [N_TERM];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < N_TERM; t++) cells_q[t] <= '0;
        end else if (we && (int'(row) < N_TERM)) begin
            cells_q[row] <= data;
        end
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        always_comb begin
            logic hit;
            hit = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                unique case (cells_q[t][2*i +: 2])
                    CELL_POS:  hit = hit & x[i];
                    CELL_NEG:  hit = hit & ~x[i];
                    CELL_FREE: hit = hit;
                    default:   hit = 1'b0;
                endcase
            end
            term_hit[t] = hit;
        end
    end

endmodule

// File: rtl/sop_sum_plane.sv
module sop_sum_plane
    import sop_pkg::*;
#(
    parameter int        N_TERM  = 16,
    parameter int        N_OUT   = 4,
    parameter int        PAL_GRP = 4,
    parameter int        ROW_W   = 4,
    parameter arr_mode_e MODE    = ARR_PLA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [N_OUT-1:0]  data,
    input  logic [N_TERM-1:0] term_hit,
    output logic [N_OUT-1:0]  sum
);

    logic [N_OUT-1:0] conn_q [N_TERM];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < N_TERM; t++) conn_q[t] <= '0;
        end else if (we && (int'(row) < N_TERM)) begin
            conn_q[row] <= data;
        end
    end

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        if (MODE == ARR_PAL) begin : g_grouped
            localparam int LO = k * PAL_GRP;
            always_comb begin
                logic acc;
                acc = 1'b0;
                for (int j = 0; j < PAL_GRP; j++) begin
                    if (LO + j < N_TERM)
                        acc = acc | (term_hit[LO + j] & conn_q[LO + j][k]);
                end
                sum[k] = acc;
            end
        end else begin : g_shared
            always_comb begin
                logic acc;
                acc = 1'b0;
                for (int t = 0; t < N_TERM; t++)
                    acc = acc | (term_hit[t] & conn_q[t][k]);
                sum[k] = acc;
            end
        end
    end

endmodule

// File: rtl/sop_array.sv
module sop_array
    import sop_pkg::*;
#(
    parameter int        N_IN    = 4,
    parameter int        N_OUT   = 4,
    parameter int        N_TERM  = 16,
    parameter int        PAL_GRP = 4,
    parameter arr_mode_e MODE    = ARR_PLA,
    parameter int        ROW_W   = (N_TERM > 1) ? $clog2(N_TERM) : 1,
    parameter int        DW      = (2 * N_IN > N_OUT) ? 2 * N_IN : N_OUT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_plane,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [DW-1:0]    wr_data,
    input  logic             commit,
    input  logic [N_IN-1:0]  x_in,
    output logic [N_OUT-1:0] f_out,
    output logic             load_done
);

    logic              prod_we;
    logic              sum_we;
    logic [N_TERM-1:0] term_hit;
    logic [N_OUT-1:0]  sum_raw;

    assign prod_we = wr_en && (wr_plane == PLANE_PROD);
    assign sum_we  = wr_en && (wr_plane == PLANE_SUM);

    sop_cfg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .commit    (commit),
        .load_done (load_done)
    );

    sop_prod_plane #(
        .N_IN   (N_IN),
        .N_TERM (N_TERM),
        .ROW_W  (ROW_W)
    ) u_prod (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (prod_we),
        .row      (wr_row),
        .data     (wr_data[2*N_IN-1:0]),
        .x        (x_in),
        .term_hit (term_hit)
    );

    sop_sum_plane #(
        .N_TERM  (N_TERM),
        .N_OUT   (N_OUT),
        .PAL_GRP (PAL_GRP),
        .ROW_W   (ROW_W),
        .MODE    (MODE)
    ) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (sum_we),
        .row      (wr_row),
        .data     (wr_data[N_OUT-1:0]),
        .term_hit (term_hit),
        .sum      (sum_raw)
    );

    assign f_out = load_done ? sum_raw : '0;

endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
    parameter int N_OUT  = 4,
    parameter int N_TERM = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              commit,
    input logic              load_done,
    input logic [N_OUT-1:0]  f_out,
    input logic [N_TERM-1:0] term_hit
);

    // R8
    gated_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_done |-> (f_out == '0));

    // R8
    write_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !load_done);

    // R8
    commit_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !wr_en) |=> load_done);

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !wr_en) |=> $stable(load_done));

    // R4
    no_term_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term_hit == '0) |-> (f_out == '0));

endmodule

bind sop_array sop_array_chk #(
    .N_OUT  (N_OUT),
    .N_TERM (N_TERM)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .commit    (commit),
    .load_done (load_done),
    .f_out     (f_out),
    .term_hit  (term_hit)
);

// File: tb/tb_sop_array.sv
module tb_sop_array;
    import sop_pkg::*;

    localparam int N_IN = 4, N_OUT = 4, N_TERM = 16, GRP = 4;
    localparam int ROW_W = 4, DW = 8;
    localparam logic [1:0] P = 2'b10, N = 2'b01, F = 2'b11, Z = 2'b00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_plane = 1'b0, commit = 1'b0;
    logic [ROW_W-1:0] wr_row = '0;
    logic [DW-1:0] wr_data = '0;
    logic [N_IN-1:0] x_in = '0;
    logic [N_OUT-1:0] f_pla, f_pal;
    logic done_pla, done_pal;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sop_array #(.MODE(ARR_PLA)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_plane(wr_plane),
        .wr_row(wr_row), .wr_data(wr_data), .commit(commit),
        .x_in(x_in), .f_out(f_pla), .load_done(done_pla));

    sop_array #(.MODE(ARR_PAL)) dut_pal (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_plane(wr_plane),
        .wr_row(wr_row), .wr_data(wr_data), .commit(commit),
        .x_in(x_in), .f_out(f_pal), .load_done(done_pal));

    // behavioural reference
    logic [1:0] m_cell [N_TERM][N_IN];
    logic [N_OUT-1:0] m_conn [N_TERM];
    bit m_done;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < N_TERM; t++) begin
                m_conn[t] = '0;
                for (int i = 0; i < N_IN; i++) m_cell[t][i] = 2'b00;
            end
            m_done = 0;
        end else if (wr_en) begin
            if (wr_plane == 1'b0)
                for (int i = 0; i < N_IN; i++) m_cell[wr_row][i] = wr_data[2*i +: 2];
            else
                m_conn[wr_row] = wr_data[N_OUT-1:0];
            m_done = 0;
        end else if (commit) begin
            m_done = 1;
        end
    end

    function automatic logic [N_OUT-1:0] model_eval(bit grouped, logic [N_IN-1:0] xv);
        logic [N_OUT-1:0] r = '0;
        if (!m_done) return '0;
        for (int t = 0; t < N_TERM; t++) begin
            bit on = 1;
            for (int i = 0; i < N_IN; i++) begin
                case (m_cell[t][i])
                    2'b00: on = 0;
                    2'b10: if (!xv[i]) on = 0;
                    2'b01: if (xv[i]) on = 0;
                    default: ;
                endcase
            end
            for (int k = 0; k < N_OUT; k++)
                if (on && m_conn[t][k] && (!grouped || (t / GRP == k))) r[k] = 1'b1;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // R7 R8: every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R7 shared cycle", {4'h0, f_pla}, {4'h0, model_eval(0, x_in)});
            chk("R6 grouped cycle", {4'h0, f_pal}, {4'h0, model_eval(1, x_in)});
            chk("R8 done", {7'h0, done_pla}, {7'h0, m_done});
        end
    end

    function automatic logic [DW-1:0] row4(logic [1:0] c3, logic [1:0] c2,
                                           logic [1:0] c1, logic [1:0] c0);
        return {c3, c2, c1, c0};
    endfunction

    task automatic wr(input logic plane, input int row, input logic [DW-1:0] d);
        @(posedge clk); #2;
        wr_en = 1; wr_plane = plane; wr_row = row[ROW_W-1:0]; wr_data = d;
        @(posedge clk); #2;
        wr_en = 0;
    endtask

    task automatic do_commit();
        @(posedge clk); #2; commit = 1;
        @(posedge clk); #2; commit = 0;
    endtask

    task automatic setx(input logic [N_IN-1:0] v);
        @(posedge clk); #2; x_in = v;
        @(negedge clk);
    endtask

    function automatic logic [3:0] golden(logic [N_IN-1:0] v);
        logic a = v[0], b = v[1], c = v[2];
        return {(~b & c) | a, (~b & ~c) | (a & b), (a & ~c) | (a & b), a | (~b & ~c)};
    endfunction

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset f", {4'h0, f_pla}, 8'h00);
        chk("R1 reset done", {7'h0, done_pla}, 8'h00);
        @(posedge clk); #2; rst_n = 1;
        setx(4'hF);
        chk("R1 empty after reset", {4'h0, f_pla}, 8'h00);

        // R9 / R5: five shared terms (A=x0, B=x1, C=x2)
        wr(0, 0, row4(F, F, P, P));
        wr(0, 1, row4(F, P, N, F));
        wr(0, 2, row4(F, N, F, P));
        wr(0, 3, row4(F, N, N, F));
        wr(0, 4, row4(F, F, F, P));
        wr(1, 0, 8'b0110);
        wr(1, 1, 8'b1000);
        wr(1, 2, 8'b0010);
        wr(1, 3, 8'b0101);
        wr(1, 4, 8'b1001);
        setx(4'h1);
        chk("R8 pending load gates outputs", {4'h0, f_pla}, 8'h00);
        do_commit();
        @(negedge clk);
        chk("R8 commit arms", {7'h0, done_pla}, 8'h01);
        for (int v = 0; v < 8; v++) begin
            setx(v[3:0]);
            chk("R9 example truth table", {4'h0, f_pla}, {4'h0, golden(v[3:0])});
        end
        setx(4'h1);
        chk("R5 term A drives F0 and F3", {4'h0, f_pla & 4'b1001}, 8'h09);
        chk("R6 grouped example", {4'h0, f_pal}, {4'h0, model_eval(1, 4'h1)});

        // R3 / R6: all-free terms 5 and 6
        wr(0, 5, row4(F, F, F, F));
        wr(1, 5, 8'b0100);
        wr(0, 6, row4(F, F, F, F));
        wr(1, 6, 8'b0010);
        @(negedge clk);
        chk("R8 write drops done", {7'h0, done_pla}, 8'h00);
        do_commit();
        setx(4'h2);
        chk("R3 free term constant shared", {4'h0, f_pla & 4'b0110}, 8'h06);
        chk("R6 out-of-group bit ignored", {4'h0, f_pal & 4'b0100}, 8'h00);
        chk("R6 in-group term reaches output 1", {4'h0, f_pal & 4'b0010}, 8'h02);

        // R2: forced-zero code
        wr(0, 5, row4(F, F, F, Z));
        wr(0, 6, row4(F, F, F, Z));
        do_commit();
        setx(4'h2);
        chk("R2 zero code kills term", {4'h0, f_pla}, {4'h0, golden(4'h2)});

        // R4: disconnect every term
        for (int t = 0; t < N_TERM; t++) wr(1, t, 8'h00);
        do_commit();
        setx(4'hF);
        chk("R4 no connection gives 0", {4'h0, f_pla}, 8'h00);
        setx(4'h0);
        chk("R4 no connection gives 0 pal", {4'h0, f_pal}, 8'h00);

        // R7 random mix
        for (int n = 0; n < 600; n++) begin
            int r;
            r = $urandom % 10;
            @(posedge clk); #2;
            wr_en = 0; commit = 0;
            if (r < 3) begin
                wr_en = 1; wr_plane = 0; wr_row = 4'($urandom); wr_data = 8'($urandom);
            end else if (r < 5) begin
                wr_en = 1; wr_plane = 1; wr_row = 4'($urandom); wr_data = 8'($urandom);
            end else if (r < 7) begin
                commit = 1;
            end else begin
                x_in = 4'($urandom);
            end
        end
        @(posedge clk); #2; wr_en = 0; commit = 0;
        repeat (2) @(negedge clk);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule